// File: doc/BRIEF.md
# DMA Page Register Bank

This block holds the upper physical address bits for a four-channel DMA engine. A host reaches it through byte-wide I/O accesses that carry a port offset and a bank select. Only the low three offset bits are decoded. Four of the eight offsets name a channel, in a fixed scrambled order, and the other four name nothing. Each channel keeps a low page byte. When the `HI_EN` parameter is set, each channel also keeps a high page byte, which lives in a bank of its own.

On the transfer side the block takes a channel number, the channel's mode byte, its 16-bit current address, and the position and length of a transfer. It returns the 31-bit start address of that transfer. The address is built from bit 0 upward: first the current address, then the low page in bits 23:16, then the lower seven bits of the high page in bits 30:24. The direction bit in the mode byte decides whether the transfer runs up from that address or ends just below it.

Top module: `dma_page_bank`

## Requirements
- R1: After reset every page byte is zero, `io_rdata` is zero, and `io_valid` and `io_err` are low.
- R2: Only `io_ofs[2:0]` is decoded and the upper offset bits are ignored. Offset 7 selects channel 0, offset 3 channel 1, offset 1 channel 2 and offset 2 channel 3.
- R3: An access at offset 0, 4, 5 or 6 stores nothing. A read there returns zero. In the cycle after the access `io_err` is high and `io_valid` is low.
- R4: A read of a decoded page returns the byte last written to it, on `io_rdata` in the cycle after the read. `io_rdata` holds its value until the next read. A decoded access raises `io_valid` for the following cycle.
- R5: `io_hi`=0 selects the low page bank and `io_hi`=1 selects the high page bank. A write to one bank leaves the other bank unchanged.
- R6: With `HI_EN`=0, an access with `io_hi`=1 is treated like an invalid offset: nothing is stored, a read returns zero and `io_err` pulses. Address bits 30:24 are then always zero.
- R7: With mode bit 5 clear, `xfer_addr` = {high[6:0], low, `xfer_cur`} + `xfer_pos`, modulo 2^31. Bit 7 of the high page never reaches the address.
- R8: With mode bit 5 set, `xfer_addr` = {high[6:0], low, `xfer_cur`} − `xfer_pos` − `xfer_len`, modulo 2^31.
- R9: `io_valid` and `io_err` are never high together. After a cycle with no access, both are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | Write strobe for this cycle |
| io_rd | input | 1 | Read strobe for this cycle |
| io_hi | input | 1 | Bank select: 0 low page, 1 high page |
| io_ofs | input | OFS_W | Port offset (low three bits decoded) |
| io_wdata | input | 8 | Write byte |
| io_rdata | output | 8 | Read byte, registered |
| io_valid | output | 1 | One-cycle pulse after a decoded access |
| io_err | output | 1 | One-cycle pulse after an undecoded access |
| xfer_chan | input | 2 | Channel whose pages form the address |
| xfer_mode | input | 8 | Channel mode byte; bit 5 selects decrement |
| xfer_cur | input | 16 | Channel current address |
| xfer_pos | input | 16 | Position within the transfer |
| xfer_len | input | 16 | Transfer length |
| xfer_addr | output | 31 | Start physical address of the transfer |

## Verification
The properties assume that `io_wr` and `io_rd` are never asserted in the same cycle. They also assume that strobes are held low while reset is active. The stimulus issues exactly one strobe per access and holds both low during reset and between accesses. The address properties read `xfer_addr` as a pure function of the transfer inputs and the stored pages. The bench therefore changes transfer inputs only on the falling edge and reads the address before the next rising edge.

// File: rtl/dma_page_bank.sv
`timescale 1ns/1ps
module dma_page_bank #(
  parameter int OFS_W = 4,
  parameter int PAGE_W = 8,
  parameter int HIGH_W = 7,
  parameter int CUR_W = 16,
  parameter bit HI_EN = 1'b1,
  localparam int PHYS_W = HIGH_W + PAGE_W + CUR_W,
  localparam int NCH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic              io_hi,
  input  logic [OFS_W-1:0]  io_ofs,
  input  logic [PAGE_W-1:0] io_wdata,
  output logic [PAGE_W-1:0] io_rdata,
  output logic              io_valid,
  output logic              io_err,
  input  logic [1:0]        xfer_chan,
  input  logic [7:0]        xfer_mode,
  input  logic [CUR_W-1:0]  xfer_cur,
  input  logic [CUR_W-1:0]  xfer_pos,
  input  logic [CUR_W-1:0]  xfer_len,
  output logic [PHYS_W-1:0] xfer_addr
);

  logic [NCH-1:0][PAGE_W-1:0] lo_q;
  logic [NCH-1:0][PAGE_W-1:0] hi_q;
  logic       hit;
  logic [1:0] ch;

  wire unused_ofs  = ^io_ofs;
  wire unused_mode = ^{xfer_mode[7:6], xfer_mode[4:0]};

  always_comb begin
    hit = 1'b1;
    ch  = 2'd0;
    unique case (io_ofs[2:0])
      3'd1: ch = 2'd2;
      3'd2: ch = 2'd3;
      3'd3: ch = 2'd1;
      3'd7: ch = 2'd0;
      default: hit = 1'b0;
    endcase
  end

  wire bank_ok = !io_hi || HI_EN;
  wire access  = io_wr || io_rd;
  wire good    = access && hit && bank_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q <= '0;
    end else begin
      for (int i = 0; i < NCH; i++)
        if (io_wr && hit && !io_hi && ch == 2'(i)) lo_q[i] <= io_wdata;
    end
  end

  generate
    if (HI_EN) begin : g_high
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          hi_q <= '0;
        end else begin
          for (int i = 0; i < NCH; i++)
            if (io_wr && hit && io_hi && ch == 2'(i)) hi_q[i] <= io_wdata;
        end
      end
    end else begin : g_no_high
      assign hi_q = '0;
    end
  endgenerate

  wire [PAGE_W-1:0] rd_val = !good ? '0 : (io_hi ? hi_q[ch] : lo_q[ch]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      io_rdata <= '0;
      io_valid <= 1'b0;
      io_err   <= 1'b0;
    end else begin
      io_valid <= good;
      io_err   <= access && !good;
      if (io_rd) io_rdata <= rd_val;
    end
  end

  wire [PHYS_W-1:0] page_base = {hi_q[xfer_chan][HIGH_W-1:0], lo_q[xfer_chan], xfer_cur};
  wire [PHYS_W-1:0] pos_x = PHYS_W'(xfer_pos);
  wire [PHYS_W-1:0] len_x = PHYS_W'(xfer_len);

  assign xfer_addr = xfer_mode[5] ? page_base - pos_x - len_x : page_base + pos_x;

endmodule

module dma_page_bank_chk #(
  parameter int CUR_W = 16,
  parameter int PHYS_W = 31,
  parameter int HIGH_W = 7,
  parameter bit HI_EN = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              io_wr,
  input logic              io_rd,
  input logic              io_hi,
  input logic [2:0]        io_ofs,
  input logic              io_valid,
  input logic              io_err,
  input logic [7:0]        io_rdata,
  input logic              xfer_dec,
  input logic [CUR_W-1:0]  xfer_cur,
  input logic [CUR_W-1:0]  xfer_pos,
  input logic [CUR_W-1:0]  xfer_len,
  input logic [PHYS_W-1:0] xfer_addr
);
  wire hole  = io_ofs == 3'd0 || io_ofs == 3'd4 || io_ofs == 3'd5 || io_ofs == 3'd6;
  wire acc   = io_wr || io_rd;
  wire legal = !hole && (!io_hi || HI_EN);

  // R3
  hole_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && hole) |=> (io_err && !io_valid));

  // R4
  legal_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && legal) |=> (io_valid && !io_err));

  // R4
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rd |=> $stable(io_rdata));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> (!io_valid && !io_err));

  // R9
  excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_valid && io_err));

  // R6
  no_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!HI_EN && acc && io_hi) |=> io_err);

  // R7
  inc_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_dec && xfer_pos == '0) |-> xfer_addr[CUR_W-1:0] == xfer_cur);

  // R8
  dec_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_dec && xfer_pos == '0 && xfer_len == '0) |-> xfer_addr[CUR_W-1:0] == xfer_cur);
endmodule

bind dma_page_bank dma_page_bank_chk #(
  .CUR_W(CUR_W), .PHYS_W(PHYS_W), .HIGH_W(HIGH_W), .HI_EN(HI_EN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd), .io_hi(io_hi),
  .io_ofs(io_ofs[2:0]), .io_valid(io_valid), .io_err(io_err), .io_rdata(io_rdata),
  .xfer_dec(xfer_mode[5]), .xfer_cur(xfer_cur), .xfer_pos(xfer_pos),
  .xfer_len(xfer_len), .xfer_addr(xfer_addr)
);

// File: tb/test_dma_page_bank.sv
`timescale 1ns/1ps
module test_dma_page_bank;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic io_wr = 1'b0, io_rd = 1'b0, io_hi = 1'b0;
  logic [3:0] io_ofs = '0;
  logic [7:0] io_wdata = '0;
  logic [1:0] xfer_chan = '0;
  logic [7:0] xfer_mode = '0;
  logic [15:0] xfer_cur = '0, xfer_pos = '0, xfer_len = '0;
  logic [7:0]  rd_a, rd_b;
  logic        vl_a, vl_b, er_a, er_b;
  logic [30:0] ad_a, ad_b;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] m_lo [4];
  logic [7:0] m_hi [4];
  logic [7:0] prev_a = '0, prev_b = '0;

  always #10 clk = ~clk;

  dma_page_bank #(.HI_EN(1'b1)) i_dma_page_bank (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd), .io_hi(io_hi),
    .io_ofs(io_ofs), .io_wdata(io_wdata), .io_rdata(rd_a), .io_valid(vl_a),
    .io_err(er_a), .xfer_chan(xfer_chan), .xfer_mode(xfer_mode),
    .xfer_cur(xfer_cur), .xfer_pos(xfer_pos), .xfer_len(xfer_len), .xfer_addr(ad_a));

  dma_page_bank #(.HI_EN(1'b0)) i_dma_page_bank_nohi (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd), .io_hi(io_hi),
    .io_ofs(io_ofs), .io_wdata(io_wdata), .io_rdata(rd_b), .io_valid(vl_b),
    .io_err(er_b), .xfer_chan(xfer_chan), .xfer_mode(xfer_mode),
    .xfer_cur(xfer_cur), .xfer_pos(xfer_pos), .xfer_len(xfer_len), .xfer_addr(ad_b));

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int chan_of(logic [3:0] ofs);
    case (ofs[2:0])
      3'd7: return 0;
      3'd3: return 1;
      3'd1: return 2;
      3'd2: return 3;
      default: return -1;
    endcase
  endfunction

  function automatic logic [30:0] exp_addr(logic [6:0] hi, logic [7:0] lo,
      logic [15:0] cur, logic [15:0] pos, logic [15:0] len, bit dec);
    logic [30:0] b;
    b = {hi, lo, cur};
    return dec ? b - 31'(pos) - 31'(len) : b + 31'(pos);
  endfunction

  task automatic access(bit wr, bit hi, logic [3:0] ofs, logic [7:0] d, string req);
    int c;
    bit ga, gb;
    logic [7:0] ea, eb;
    c  = chan_of(ofs);
    ga = (c >= 0);
    gb = (c >= 0) && !hi;
    ea = prev_a;
    eb = prev_b;
    if (!wr) begin
      ea = ga ? (hi ? m_hi[c] : m_lo[c]) : 8'h00;
      eb = gb ? m_lo[c] : 8'h00;
    end
    @(negedge clk);
    io_wr = wr; io_rd = !wr; io_hi = hi; io_ofs = ofs; io_wdata = d;
    @(negedge clk);
    io_wr = 1'b0; io_rd = 1'b0;
    chk({req, " valid"}, vl_a, ga);
    chk({req, " err"}, er_a, !ga);
    chk({req, " rdata"}, rd_a, ea);
    chk({req, " R6 nohi valid"}, vl_b, gb);
    chk({req, " R6 nohi err"}, er_b, !gb);
    chk({req, " R6 nohi rdata"}, rd_b, eb);
    prev_a = ea; prev_b = eb;
    if (wr && ga) begin
      if (hi) m_hi[c] = d; else m_lo[c] = d;
    end
  endtask

  task automatic xfer(logic [1:0] c, bit dec, logic [15:0] cur, logic [15:0] pos,
      logic [15:0] len, string req);
    @(negedge clk);
    xfer_chan = c; xfer_mode = 8'($urandom) & 8'hDF | (dec ? 8'h20 : 8'h00);
    xfer_cur = cur; xfer_pos = pos; xfer_len = len;
    #2;
    chk({req, " addr"}, ad_a, exp_addr(m_hi[c][6:0], m_lo[c], cur, pos, len, dec));
    chk({req, " R6 nohi addr"}, ad_b, exp_addr(7'd0, m_lo[c], cur, pos, len, dec));
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 4; i++) begin m_lo[i] = 8'h00; m_hi[i] = 8'h00; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rdata", rd_a, 8'h00);
    chk("R1 valid", vl_a, 1'b0);
    chk("R1 err", er_a, 1'b0);
    xfer(2'd0, 1'b0, 16'h0000, 16'h0000, 16'h0000, "R1 zero pages");
    // R2 scrambled map: each channel gets a distinct value, then each is read
    access(1'b1, 1'b0, 4'd7, 8'hA0, "R2 ch0 wr");
    access(1'b1, 1'b0, 4'd3, 8'hB1, "R2 ch1 wr");
    access(1'b1, 1'b0, 4'd1, 8'hC2, "R2 ch2 wr");
    access(1'b1, 1'b0, 4'd2, 8'hD3, "R2 ch3 wr");
    access(1'b0, 1'b0, 4'd7, 8'h00, "R2 ch0 rd");
    access(1'b0, 1'b0, 4'd3, 8'h00, "R2 ch1 rd");
    access(1'b0, 1'b0, 4'd1, 8'h00, "R2 ch2 rd");
    access(1'b0, 1'b0, 4'd2, 8'h00, "R2 ch3 rd");
    // R2 upper offset bits ignored
    access(1'b1, 1'b0, 4'hB, 8'h5A, "R2 alias wr");
    access(1'b0, 1'b0, 4'h3, 8'h00, "R2 alias rd");
    // R3 holes: writes dropped, reads zero
    access(1'b1, 1'b0, 4'd0, 8'hFF, "R3 hole0 wr");
    access(1'b1, 1'b1, 4'd4, 8'hFF, "R3 hole4 wr");
    access(1'b0, 1'b0, 4'd5, 8'h00, "R3 hole5 rd");
    access(1'b0, 1'b1, 4'd6, 8'h00, "R3 hole6 rd");
    access(1'b0, 1'b0, 4'd7, 8'h00, "R3 ch0 untouched");
    // R5 bank independence
    access(1'b1, 1'b1, 4'd7, 8'hFE, "R5 hi ch0 wr");
    access(1'b0, 1'b0, 4'd7, 8'h00, "R5 lo ch0 kept");
    access(1'b0, 1'b1, 4'd7, 8'h00, "R5 hi ch0 rd");
    // R4 rdata holds across a write
    access(1'b1, 1'b0, 4'd1, 8'h11, "R4 hold wr");
    // R7 high bit 7 masked, increment
    xfer(2'd0, 1'b0, 16'h1234, 16'h0010, 16'h0100, "R7 inc");
    xfer(2'd0, 1'b0, 16'hFFFF, 16'hFFFF, 16'h0000, "R7 carry");
    // R8 decrement including wrap below zero
    xfer(2'd0, 1'b1, 16'h1000, 16'h0020, 16'h0040, "R8 dec");
    xfer(2'd3, 1'b1, 16'h0000, 16'h0001, 16'h0001, "R8 borrow");
    access(1'b1, 1'b0, 4'd2, 8'h00, "R8 clr ch3");
    xfer(2'd3, 1'b1, 16'h0000, 16'h0000, 16'h0001, "R8 wrap");
    // R6 no-high instance checked in every access; directed high write
    access(1'b1, 1'b1, 4'd3, 8'h7F, "R6 hi wr");
    access(1'b0, 1'b1, 4'd3, 8'h00, "R6 hi rd");
    xfer(2'd1, 1'b0, 16'h0001, 16'h0000, 16'h0000, "R6 hi bits");
    // R9 idle cycle: no pulses
    @(negedge clk);
    chk("R9 idle valid", vl_a, 1'b0);
    chk("R9 idle err", er_a, 1'b0);
    // random mix
    for (int n = 0; n < 400; n++) begin
      access(1'($urandom), 1'($urandom), 4'($urandom), 8'($urandom), "R4 rand");
      if (n % 4 == 0)
        xfer(2'($urandom), 1'($urandom), 16'($urandom), 16'($urandom),
             16'($urandom), "R7 R8 rand");
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule